// File: doc/BRIEF.md
# POST Code Assembler

This block rebuilds multi-byte power-on self-test codes from a stream of byte entries. Each entry carries one data byte and a small lane tag that says where the byte belongs inside a 32-bit code word. The stream usually comes out of the capture FIFO of a host I/O snoop path. Bytes belonging to one code are merged into an accumulator, and each finished code leaves through a valid/ready output port.

No explicit start-of-code marker exists. The block infers code boundaries by holding one entry in a lookahead register. It folds that entry into the accumulator only after it has seen the entry that follows. A held entry closes its code in two cases: when the next well-formed entry carries lane tag zero, or when the held entry is the final one of its burst. Entries whose lane tag falls outside the code word are dropped, and a sticky error flag records that this happened.

The input side uses a valid/ready handshake with a `last` marker on the final entry of each burst. When the output register holds a code that has not been taken yet, the block stops accepting input.

Top module: `post_code_assembler`

## Requirements
- R1: A well-formed entry with lane tag `t` (0 to 3) ORs its data byte into bits `[8*t+7 : 8*t]` of the code being built. Every other bit is left as it was, so a repeated tag ORs onto the same lane.
- R2: When a well-formed entry with tag 0 follows a held entry of the same burst, the code that contains the held entry is emitted first. The new entry then starts a fresh code at zero.
- R3: The final well-formed entry of a burst (`in_last` = 1) closes its code, and that code is emitted without waiting for further input.
- R4: An entry with tag 4 to 7 is accepted but contributes no data and does not count as a following entry for R2. It sets `err_flag`, which stays at 1 until reset.
- R5: A malformed entry that carries `in_last` = 1 still ends the burst, so a code under construction in that burst is emitted.
- R6: A burst that holds no well-formed entry emits no code.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_code` and `out_valid` hold their values. While a held entry is waiting, `in_ready` is 0.
- R8: After reset, `out_valid` = 0, `err_flag` = 0, `in_ready` = 1 and the accumulator is zero.
- R9: Codes leave in the order they were completed. No byte of one code appears in the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input entry present |
| in_ready | output | 1 | Block can take the entry |
| in_data | input | 8 | Entry data byte |
| in_ofs | input | 3 | Entry lane tag |
| in_last | input | 1 | Entry is the final one of its burst |
| out_valid | output | 1 | A completed code is on `out_code` |
| out_ready | input | 1 | Consumer takes the code |
| out_code | output | 32 | Completed code |
| err_flag | output | 1 | Sticky: a malformed lane tag was seen |

## Verification
The bench aims at the places where the boundary inference can go wrong.

- **Tag-0 entry in mid-burst.** A design that merged before looking ahead would fold this byte into the old code.
- **Tag-0 entry following a higher lane.** A design that treated only the first entry of a burst as a start would glue two codes together.
- **Burst ending on a malformed entry.** A design that ignored the `last` marker on a dropped entry would keep a finished code stuck until the next burst.
- **Burst of malformed entries only.** A sloppy flush would emit a spurious zero code here.
- **Output stall.** A second completion arriving during a stall must not overwrite the pending code, and a design that failed here would lose or corrupt codes.

Random traffic with a throttled consumer then compares every emitted code against a bench model of the lookahead rule.

// File: rtl/pca_pkg.sv
package pca_pkg;
  // What happens to the held entry in a given cycle.
  typedef enum logic [1:0] {
    RET_NONE  = 2'd0,  // entry stays held
    RET_MERGE = 2'd1,  // folded into accumulator, code continues
    RET_EMIT  = 2'd2   // folded and the code is closed
  } retire_e;

  function automatic int unsigned code_width(input int unsigned dw, input int unsigned lanes);
    return dw * lanes;
  endfunction
endpackage

// File: rtl/pca_tag_check.sv
module pca_tag_check #(
  parameter int unsigned OFS_W = 3,
  parameter int unsigned LANES = 4
) (
  input  logic [OFS_W-1:0] tag,
  output logic             tag_ok
);
  always_comb tag_ok = (int'(tag) < int'(LANES));
endmodule

// File: rtl/pca_lane_merge.sv
module pca_lane_merge #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LANES  = 4,
  parameter int unsigned OFS_W  = 3,
  localparam int unsigned CODE_W = DATA_W * LANES
) (
  input  logic [CODE_W-1:0] acc,
  input  logic [DATA_W-1:0] data,
  input  logic [OFS_W-1:0]  tag,
  output logic [CODE_W-1:0] merged
);
  for (genvar i = 0; i < int'(LANES); i++) begin : g_lane
    logic hit;
    assign hit = (int'(tag) == i);
    assign merged[i*DATA_W +: DATA_W] = acc[i*DATA_W +: DATA_W] | (hit ? data : '0);
  end
endmodule

// File: rtl/pca_out_reg.sv
module pca_out_reg #(
  parameter int unsigned CODE_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CODE_W-1:0] code_in,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [CODE_W-1:0] out_code,
  output logic              slot_free
);
  always_comb slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_code  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_code  <= code_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/post_code_assembler.sv
module post_code_assembler #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LANES  = 4,
  parameter int unsigned OFS_W  = 3,
  localparam int unsigned CODE_W = DATA_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [OFS_W-1:0]  in_ofs,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CODE_W-1:0] out_code,
  output logic              err_flag
);
  import pca_pkg::*;

  // lookahead register
  logic              h_valid;
  logic [DATA_W-1:0] h_data;
  logic [OFS_W-1:0]  h_ofs;
  logic              h_last;

  logic [CODE_W-1:0] acc;
  logic [CODE_W-1:0] merged;
  logic              tag_ok;
  logic              slot_free;
  logic              in_fire, good_fire, bad_fire;
  logic              next_is_start, retire_go;
  retire_e           ret_kind;

  pca_tag_check #(.OFS_W(OFS_W), .LANES(LANES)) u_tag (
    .tag    (in_ofs),
    .tag_ok (tag_ok)
  );

  pca_lane_merge #(.DATA_W(DATA_W), .LANES(LANES), .OFS_W(OFS_W)) u_merge (
    .acc    (acc),
    .data   (h_data),
    .tag    (h_ofs),
    .merged (merged)
  );

  always_comb begin
    in_ready      = !h_valid || slot_free;
    in_fire       = in_valid && in_ready;
    good_fire     = in_fire && tag_ok;
    bad_fire      = in_fire && !tag_ok;
    next_is_start = good_fire && (in_ofs == '0);
    retire_go     = h_valid && ((h_last && slot_free) || good_fire);
    if (!retire_go)                    ret_kind = RET_NONE;
    else if (h_last || next_is_start)  ret_kind = RET_EMIT;
    else                               ret_kind = RET_MERGE;
  end

  pca_out_reg #(.CODE_W(CODE_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (ret_kind == RET_EMIT),
    .code_in   (merged),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_code  (out_code),
    .slot_free (slot_free)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else begin
      case (ret_kind)
        RET_EMIT:  acc <= '0;
        RET_MERGE: acc <= merged;
        default:   acc <= acc;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_valid <= 1'b0;
      h_data  <= '0;
      h_ofs   <= '0;
      h_last  <= 1'b0;
    end else if (good_fire) begin
      h_valid <= 1'b1;
      h_data  <= in_data;
      h_ofs   <= in_ofs;
      h_last  <= in_last;
    end else if (retire_go) begin
      h_valid <= 1'b0;
      h_last  <= 1'b0;
    end else if (bad_fire && in_last && h_valid) begin
      h_last  <= 1'b1;  // dropped entry still closes the burst
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           err_flag <= 1'b0;
    else if (bad_fire) err_flag <= 1'b1;
  end
endmodule

// File: rtl/pca_checker.sv
module pca_checker #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned OFS_W  = 3,
  parameter int unsigned CODE_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [OFS_W-1:0]  in_ofs,
  input logic              out_valid,
  input logic              out_ready,
  input logic [CODE_W-1:0] out_code,
  input logic              err_flag,
  input logic              h_valid
);
  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_code));

  assert_input_stall_R7: assert property (@(posedge clk) disable iff (rst)
    h_valid && out_valid && !out_ready |-> !in_ready);

  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);

  assert_bad_tag_sets_err_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && (int'(in_ofs) >= int'(LANES)) |=> err_flag);

  assert_no_spurious_code_R6: assert property (@(posedge clk) disable iff (rst)
    !h_valid && in_valid && in_ready && (int'(in_ofs) >= int'(LANES)) |=> !$rose(out_valid));
endmodule

bind post_code_assembler pca_checker #(.LANES(LANES), .OFS_W(OFS_W), .CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_ofs    (in_ofs),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_code  (out_code),
  .err_flag  (err_flag),
  .h_valid   (h_valid)
);

// File: tb/sim_post_code_assembler.sv
`timescale 1ns/1ps
module sim_post_code_assembler;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic [2:0]  in_ofs = '0;
  logic        in_last = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_code;
  logic        err_flag;

  int checks = 0;
  int fails  = 0;
  int rdy_mode = 1;  // 0 random, 1 always ready, 2 never ready
  logic [31:0] exp_q [$];
  bit          exp_err = 1'b0;
  logic [7:0]  bd [8];
  logic [2:0]  bo [8];

  always #10 clk = ~clk;  // 50 MHz

  post_code_assembler u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_ofs(in_ofs), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code),
    .err_flag(err_flag)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    #2;
    case (rdy_mode)
      0:       out_ready = ($urandom_range(0, 9) < 7);
      2:       out_ready = 1'b0;
      default: out_ready = 1'b1;
    endcase
  end

  // output monitor: R1/R2/R3/R9 code content and order, R6 no stray code
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected code", out_code, 32'h0);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        check(out_code === e, "R1/R2/R3/R9 code", out_code, e);
      end
    end
  end

  initial begin
    #(20ns * 150000);
    check(1'b0, "watchdog", 32'h0, 32'h0);
    finish_run();
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_q.delete();
    exp_err = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic [2:0] o, input logic l);
    bit done = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_ofs = o; in_last = l;
    while (!done) begin
      #5;
      done = in_ready;
      @(posedge clk);
      if (!done) @(negedge clk);
    end
  endtask

  // bench model of the lookahead rule, then drive the burst
  task automatic run_burst(input int n);
    int vi [$];
    logic [31:0] code = '0;
    for (int i = 0; i < n; i++) begin
      if (bo[i] < 3'd4) vi.push_back(i);
      else exp_err = 1'b1;
    end
    for (int k = 0; k < vi.size(); k++) begin
      code |= 32'(bd[vi[k]]) << (8 * bo[vi[k]]);
      if (k == vi.size() - 1 || bo[vi[k+1]] == 3'd0) begin
        exp_q.push_back(code);
        code = '0;
      end
    end
    for (int i = 0; i < n; i++) send(bd[i], bo[i], i == n - 1);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain_and_check_err(input string req);
    for (int i = 0; i < 4000 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, {req, " all codes out"}, 32'(exp_q.size()), 32'h0);
    check(err_flag === exp_err, {req, " err_flag"}, 32'(err_flag), 32'(exp_err));
  endtask

  initial begin
    void'($urandom(32'h5EED_0017));
    do_reset();
    // R8 reset state
    check(out_valid === 1'b0, "R8 out_valid", 32'(out_valid), 32'h0);
    check(in_ready === 1'b1, "R8 in_ready", 32'(in_ready), 32'h1);
    check(err_flag === 1'b0, "R8 err_flag", 32'(err_flag), 32'h0);

    // R1 R3: four lanes -> 0xEEE20400
    bd[0]=8'h00; bo[0]=0; bd[1]=8'h04; bo[1]=1; bd[2]=8'hE2; bo[2]=2; bd[3]=8'hEE; bo[3]=3;
    run_burst(4); drain_and_check_err("R1");
    // R3: single byte -> 0x000000AA (also proves the accumulator was cleared, R9)
    bd[0]=8'hAA; bo[0]=0; run_burst(1); drain_and_check_err("R3");
    // R2: tag 0 mid-burst splits codes
    bd[0]=8'h11; bo[0]=0; bd[1]=8'h22; bo[1]=1; bd[2]=8'h33; bo[2]=0;
    run_burst(3); drain_and_check_err("R2");
    // R2: higher lane followed by tag 0
    bd[0]=8'h44; bo[0]=2; bd[1]=8'h55; bo[1]=0; run_burst(2); drain_and_check_err("R2");
    // R1: repeated lane ORs
    bd[0]=8'h0F; bo[0]=1; bd[1]=8'hF0; bo[1]=1; run_burst(2); drain_and_check_err("R1");
    // R4: malformed entry in the middle is skipped
    bd[0]=8'h01; bo[0]=0; bd[1]=8'h99; bo[1]=5; bd[2]=8'h02; bo[2]=1;
    run_burst(3); drain_and_check_err("R4");
    // R4: malformed tag-0 lookalike does not split (tag 4 is not 0)
    do_reset();
    bd[0]=8'h61; bo[0]=1; bd[1]=8'h62; bo[1]=4; bd[2]=8'h63; bo[2]=0;
    run_burst(3); drain_and_check_err("R4");
    // R5: burst ends on a malformed entry
    do_reset();
    bd[0]=8'h07; bo[0]=0; bd[1]=8'h08; bo[1]=6; run_burst(2); drain_and_check_err("R5");
    // R6: burst with only malformed entries
    do_reset();
    bd[0]=8'hFF; bo[0]=7; run_burst(1); drain_and_check_err("R6");
    bd[0]=8'hFE; bo[0]=4; bd[1]=8'hFD; bo[1]=5; run_burst(2); drain_and_check_err("R6");

    // R7: output stall holds code and blocks input
    do_reset();
    rdy_mode = 2;
    bd[0]=8'h11; bo[0]=0; bd[1]=8'h22; bo[1]=0; bd[2]=8'h33; bo[2]=0;
    fork run_burst(3); join_none
    repeat (20) @(negedge clk);
    check(out_valid === 1'b1, "R7 out_valid held", 32'(out_valid), 32'h1);
    check(out_code === 32'h11, "R7 out_code held", out_code, 32'h11);
    check(in_ready === 1'b0, "R7 in_ready low", 32'(in_ready), 32'h0);
    rdy_mode = 1;
    wait fork;
    drain_and_check_err("R7");

    // random traffic with throttled consumer
    do_reset();
    rdy_mode = 0;
    for (int b = 0; b < 300; b++) begin
      int n;
      n = $urandom_range(1, 8);
      for (int i = 0; i < n; i++) begin
        bd[i] = 8'($urandom_range(0, 255));
        bo[i] = ($urandom_range(0, 99) < 85) ? 3'($urandom_range(0, 3)) : 3'($urandom_range(4, 7));
      end
      run_burst(n);
      if (b % 25 == 24) drain_and_check_err("R9");
    end
    drain_and_check_err("R9");
    finish_run();
  end
endmodule